// File: doc/BRIEF.md
# Indirect-Addressed MDIO Management Master

This block is the station-management master that sits beside a 10G Ethernet MAC. Software reaches it through a small 32-bit register bus with four word registers: configuration/status, command, register address and data. It drives the management clock (MDC) from a programmable divider of the system clock. It drives the management data line as an output value plus an output enable, and it samples the line through a separate input.

Access to a PHY register takes two frames, because the addressing is indirect. A write of the register-address register sends an address frame, which names the register inside the target device. A write of the data register then sends a write frame. Setting the read bit in the command register instead sends a read frame, and the returned 16-bit value lands in the data register. A frame-busy flag in the status register and a data-busy flag in the data register tell software when each operation has finished. A read-error flag reports a PHY that did not answer in the turnaround slot.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After synchronous active-low reset, every register reads as zero, MDC is low and the data line is released (`mdio_oe` = 0).
- R2: Bits [DIV_W-1:0] of the configuration/status register (bus address 0) set the MDC half period in system clocks. The value 0 acts as 1. A frame lasts 128 × max(div,1) clocks, and bit 31 of that register (frame busy) is set for exactly that time. The first MDC rise comes max(div,1) clocks after the frame starts.
- R3: The command register (address 1) holds the device address in bits [4:0] and the port address in bits [9:5]. A bus write to the register-address register (address 2) starts an address frame. The frame carries, in order on successive MDC rising edges: 32 ones, start 00, op 00, the port address, the device address, turnaround 10, and the 16-bit register number, each field MSB first.
- R4: A bus write to the data register (address 3) stores bits [15:0] and starts a write frame with op 01 that carries that value. Bit 31 of the data register (data busy) is set for the whole write frame, 128 × max(div,1) clocks.
- R5: A bus write to the command register with bit 15 set stores the new port and device addresses and starts a read frame with op 11. The master releases the line for both turnaround bits and all 16 data bits. It samples the line on the 16 MDC rising edges after turnaround, MSB first. The sampled value sits in data register bits [15:0] from the clock on which data busy clears.
- R6: Bit 30 of the configuration/status register (read error) is set when the line is high at the MDC rising edge of the second turnaround bit of a read frame. The flag is cleared when the next read frame starts and is left unchanged by address and write frames.
- R7: While frame busy is set, bus writes to any of the four registers are ignored. They change no register and start no frame.
- R8: The master changes its driven MDIO value only when MDC falls. The value is stable for as long as MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word register select (0 cfg/status, 1 command, 2 register address, 3 data) |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data line as seen at the pin |

## Verification
Frame busy rises on the clock edge that takes the launching write and falls exactly 128 × max(div,1) edges later. The first MDC rise comes max(div,1) edges after launch. The bench samples the busy bits and MDC on falling clock edges, counting from the first falling edge after the launching write. A scoreboard queue holds one expected item per MDC rising edge. The monitor compares the line one time step after each rise, where the driven value has been settled since the previous MDC fall. The PHY responder drives the line one time step after each MDC fall. The data register and the error flag are read back only after busy is seen low, which R5 defines as the clock on which the value is already present.

// File: rtl/mdio_pkg.sv
// Package: shared frame constants, op codes and register indices for the
// MDIO management master. Assumes 64-bit frames with a full preamble.
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA2_IDX    = 47;
    localparam int DATA_IDX   = 48;
    localparam int REL_IDX    = 46;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b11
    } mdio_op_e;

    localparam logic [1:0] RA_CFG = 2'd0;
    localparam logic [1:0] RA_CMD = 2'd1;
    localparam logic [1:0] RA_REG = 2'd2;
    localparam logic [1:0] RA_DAT = 2'd3;
endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC generator: while run is high, toggles mdc every max(div,1) clocks,
// starting low. Emits one-clock tick pulses on the clock edge where mdc
// rises or falls. Assumes div is held stable while run is high.
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff_div;
    logic             wrap;

    // Zero divider behaves as one so MDC never stalls mid-frame.
    always_comb begin
        eff_div   = (div == '0) ? DIV_W'(1) : div;
        wrap      = run && (cnt == eff_div - DIV_W'(1));
        rise_tick = wrap && !mdc;
        fall_tick = wrap && mdc;
    end

    // Half-period counter and MDC toggle register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_tick || fall_tick) |-> run); // R2
endmodule

// File: rtl/mdio_frame_shifter.sv
// Frame shifter: on start, loads a 64-bit management frame and shifts it out
// MSB first, advancing one bit per MDC falling tick. For read frames it
// releases the line from the first turnaround bit, checks the second
// turnaround bit and captures 16 data bits on MDC rising ticks.
// Assumes start is only asserted while busy is low.
module mdio_frame_shifter
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_op_e    op,
    input  logic [4:0]  port_ad,
    input  logic [4:0]  dev_ad,
    input  logic [15:0] payload,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        data_busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        rd_err,
    output logic        rd_done,
    output logic [15:0] rd_value
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [FRAME_BITS-1:0] frame;
    logic [IDX_W-1:0]      idx;
    logic                  is_read;
    logic [1:0]            ta_bits;

    // Assemble the frame image from the launch fields.
    always_comb begin
        ta_bits = (op == OP_READ) ? 2'b11 : 2'b10;
        frame   = {32'hFFFF_FFFF, 2'b00, op, port_ad, dev_ad, ta_bits, payload};
    end

    // Line drive: released when idle and during read turnaround/data.
    always_comb begin
        mdio_o  = busy ? shreg[FRAME_BITS-1] : 1'b1;
        mdio_oe = busy && !(is_read && idx >= IDX_W'(REL_IDX));
        rd_done = busy && is_read && fall_tick && (idx == LAST_IDX);
    end

    // Frame sequencing, read sampling and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            data_busy <= 1'b0;
            is_read   <= 1'b0;
            idx       <= '0;
            shreg     <= '0;
            rd_err    <= 1'b0;
            rd_value  <= '0;
        end else if (start) begin
            busy      <= 1'b1;
            data_busy <= (op != OP_ADDR);
            is_read   <= (op == OP_READ);
            idx       <= '0;
            shreg     <= frame;
            if (op == OP_READ) rd_err <= 1'b0;
        end else if (busy) begin
            if (rise_tick && is_read) begin
                if (idx == IDX_W'(TA2_IDX)) rd_err <= mdio_i;
                if (idx >= IDX_W'(DATA_IDX)) rd_value <= {rd_value[14:0], mdio_i};
            end
            if (fall_tick) begin
                if (idx == LAST_IDX) begin
                    busy      <= 1'b0;
                    data_busy <= 1'b0;
                end else begin
                    idx   <= idx + IDX_W'(1);
                    shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end

    AST_ERR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_err) |-> is_read); // R6
    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !busy); // R5
endmodule

// File: rtl/mdio_mgmt_master.sv
// MDIO management master top: register file on a simple 32-bit bus, frame
// launch decode, MDC generator and frame shifter. Writes are ignored while
// a frame is in flight. Assumes one write strobe per bus write.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int CFG_PAD = 30 - DIV_W;

    logic [DIV_W-1:0] div_q;
    logic [4:0]       port_q;
    logic [4:0]       dev_q;
    logic [15:0]      regaddr_q;
    logic [15:0]      data_q;

    logic             busy;
    logic             data_busy;
    logic             rd_err;
    logic             rd_done;
    logic [15:0]      rd_value;
    logic             rise_tick;
    logic             fall_tick;
    logic             wr_ok;
    logic             start;
    mdio_op_e         start_op;
    logic [4:0]       start_port;
    logic [4:0]       start_dev;

    // Launch decode: which write starts which frame, and with what fields.
    always_comb begin
        wr_ok      = bus_wr && !busy;
        start      = 1'b0;
        start_op   = OP_ADDR;
        start_port = port_q;
        start_dev  = dev_q;
        if (wr_ok) begin
            unique case (bus_addr)
                RA_REG: start = 1'b1;
                RA_DAT: begin
                    start    = 1'b1;
                    start_op = OP_WRITE;
                end
                RA_CMD: begin
                    start      = bus_wdata[15];
                    start_op   = OP_READ;
                    start_port = bus_wdata[9:5];
                    start_dev  = bus_wdata[4:0];
                end
                default: start = 1'b0;
            endcase
        end
    end

    // Register file updates from the bus and from read completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q     <= '0;
            port_q    <= '0;
            dev_q     <= '0;
            regaddr_q <= '0;
            data_q    <= '0;
        end else if (wr_ok) begin
            unique case (bus_addr)
                RA_CFG: div_q     <= bus_wdata[DIV_W-1:0];
                RA_CMD: begin
                    port_q <= bus_wdata[9:5];
                    dev_q  <= bus_wdata[4:0];
                end
                RA_REG: regaddr_q <= bus_wdata[15:0];
                RA_DAT: data_q    <= bus_wdata[15:0];
                default: ;
            endcase
        end else if (rd_done) begin
            data_q <= rd_value;
        end
    end

    // Read mux of the four word registers.
    always_comb begin
        unique case (bus_addr)
            RA_CFG:  bus_rdata = {busy, rd_err, {CFG_PAD{1'b0}}, div_q};
            RA_CMD:  bus_rdata = {22'b0, port_q, dev_q};
            RA_REG:  bus_rdata = {16'b0, regaddr_q};
            default: bus_rdata = {data_busy, 15'b0, data_q};
        endcase
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (start_op),
        .port_ad   (start_port),
        .dev_ad    (start_dev),
        .payload   (bus_wdata[15:0]),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .data_busy (data_busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_err    (rd_err),
        .rd_done   (rd_done),
        .rd_value  (rd_value)
    );

    AST_MDC_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc); // R2
    AST_DBUSY_WITHIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        data_busy |-> busy); // R4
    AST_RELEASE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mdio_oe) |-> data_busy); // R5
    AST_REGS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(regaddr_q) && $stable(port_q) && $stable(div_q))); // R7
    AST_DRIVE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o)); // R8
endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    typedef struct { logic val; logic drv; string tag; } exp_bit_t;
    exp_bit_t exp_q[$];
    exp_bit_t mon_item;
    logic     held_val;

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: one expected item per MDC rise.
    task automatic push_frame(input logic [1:0] op, input logic [4:0] prt,
                              input logic [4:0] dev, input logic [15:0] dat,
                              input string tag);
        logic [63:0] img;
        img = {32'hFFFF_FFFF, 2'b00, op, prt, dev, 2'b10, dat};
        for (int i = 63; i >= 0; i--) begin
            exp_bit_t e;
            e.val = img[i];
            e.drv = !(op == 2'b11 && i <= 17);
            e.tag = tag;
            exp_q.push_back(e);
        end
    endtask

    // Monitor: compare the line one step after each MDC rise.
    always @(posedge mdc) begin
        #1;
        held_val = mdio_o;
        if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected MDC edge", 32'd1, 32'd0);
        end else begin
            mon_item = exp_q.pop_front();
            check(mdio_oe === mon_item.drv, mon_item.tag, "line enable at MDC rise",
                  {31'b0, mdio_oe}, {31'b0, mon_item.drv});
            if (mon_item.drv)
                check(mdio_o === mon_item.val, mon_item.tag, "driven bit at MDC rise",
                      {31'b0, mdio_o}, {31'b0, mon_item.val});
        end
    end

    // R8: driven value holds while MDC is high.
    always @(negedge clk) begin
        if (rst_n && mdc && mdio_oe)
            check(mdio_o === held_val, "R8", "MDIO moved while MDC high",
                  {31'b0, mdio_o}, {31'b0, held_val});
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr   = 1'b0;
        bus_addr = 2'd0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 2'd0;
    endtask

    // Count falling-edge samples with bit 31 of register a set.
    task automatic wait_idle(input logic [1:0] a, output int cycles, output int first_rise);
        cycles = 0;
        first_rise = -1;
        bus_addr = a;
        forever begin
            @(negedge clk);
            if (!bus_rdata[31]) break;
            if (mdc && first_rise < 0) first_rise = cycles;
            cycles++;
        end
        bus_addr = 2'd0;
    endtask

    // PHY responder for one read frame.
    task automatic phy_answer(input logic ta2, input logic [15:0] dat);
        wait (mdio_oe == 1'b1);
        wait (mdio_oe == 1'b0);
        #1 mdio_i = 1'b1;
        @(negedge mdc);
        #1 mdio_i = ta2;
        for (int i = 15; i >= 0; i--) begin
            @(negedge mdc);
            #1 mdio_i = dat[i];
        end
        @(negedge mdc);
        #1 mdio_i = 1'b1;
    endtask

    task automatic do_read(input logic [4:0] prt, input logic [4:0] dev,
                           input logic ta2, input logic [15:0] dat, input int div_eff);
        int cyc, fr;
        logic [31:0] r;
        push_frame(2'b11, prt, dev, 16'h0, "R5");
        bus_write(2'd1, {16'h0, 1'b1, 5'b0, prt, dev});
        fork
            phy_answer(ta2, dat);
            wait_idle(2'd3, cyc, fr);
        join
        check(cyc == 128 * div_eff, "R5", "read data-busy length", cyc, 128 * div_eff);
        bus_read(2'd3, r);
        check(r == {16'h0, dat}, "R5", "read value in data register", r, {16'h0, dat});
        bus_read(2'd0, r);
        check(r[30] == ta2, "R6", "read error flag", {31'b0, r[30]}, {31'b0, ta2});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int cyc, fr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), r);
            check(r == 32'h0, "R1", "register after reset", r, 32'h0);
        end
        check(!mdc && !mdio_oe, "R1", "MDC/enable after reset", {30'b0, mdc, mdio_oe}, 32'h0);

        // R2/R3: divider 3, address frame
        bus_write(2'd0, 32'h3);
        bus_read(2'd0, r);
        check(r == 32'h3, "R2", "divider readback", r, 32'h3);
        bus_write(2'd1, 32'h0000_026A);
        bus_read(2'd1, r);
        check(r == 32'h0000_026A, "R3", "command fields readback", r, 32'h26A);
        push_frame(2'b00, 5'h13, 5'h0A, 16'hA5C3, "R3");
        bus_write(2'd2, 32'h0000_A5C3);
        wait_idle(2'd0, cyc, fr);
        check(cyc == 384, "R2", "frame busy length div 3", cyc, 384);
        check(fr == 3, "R2", "first MDC rise div 3", fr, 3);

        // R2/R4: divider 0 acts as 1, write frame with data busy
        bus_write(2'd0, 32'h0);
        push_frame(2'b01, 5'h13, 5'h0A, 16'h1234, "R4");
        bus_write(2'd3, 32'h0000_1234);
        wait_idle(2'd3, cyc, fr);
        check(cyc == 128, "R4", "data busy length div 0", cyc, 128);
        check(fr == 1, "R2", "first MDC rise div 0", fr, 1);
        bus_read(2'd3, r);
        check(r == 32'h1234, "R4", "written data kept", r, 32'h1234);

        // R5/R6: reads with divider 2
        bus_write(2'd0, 32'h2);
        do_read(5'h1F, 5'h01, 1'b0, 16'hC0DE, 2);
        do_read(5'h02, 5'h1E, 1'b1, 16'h8001, 2);
        do_read(5'h00, 5'h05, 1'b0, 16'h7FFE, 2);
        bus_read(2'd1, r);
        check(r == 32'h0000_0005, "R5", "read updates command fields", r, 32'h5);

        // R6: address and write frames leave the error flag alone
        do_read(5'h04, 5'h04, 1'b1, 16'h0F0F, 2);
        push_frame(2'b00, 5'h04, 5'h04, 16'h0101, "R3");
        bus_write(2'd2, 32'h0000_0101);
        wait_idle(2'd0, cyc, fr);
        bus_read(2'd0, r);
        check(r[30] == 1'b1, "R6", "error kept over address frame", {31'b0, r[30]}, 32'h1);

        // R7: writes during a frame are ignored
        push_frame(2'b00, 5'h04, 5'h04, 16'h0F0F, "R3");
        bus_write(2'd2, 32'h0000_0F0F);
        bus_write(2'd2, 32'h0000_BEEF);
        bus_write(2'd3, 32'h0000_5555);
        bus_write(2'd1, 32'h0000_8000);
        bus_write(2'd0, 32'h0000_0007);
        wait_idle(2'd0, cyc, fr);
        repeat (20) @(negedge clk);
        bus_read(2'd2, r);
        check(r == 32'h0F0F, "R7", "register address unchanged", r, 32'h0F0F);
        bus_read(2'd3, r);
        check(r[15:0] == 16'h0F0F, "R7", "data unchanged", r, 32'h0F0F);
        bus_read(2'd1, r);
        check(r == 32'h0084, "R7", "command unchanged", r, 32'h84);
        bus_read(2'd0, r);
        check(r[7:0] == 8'h2 && !r[31], "R7", "divider unchanged, idle", r, 32'h4000_0002);
        check(exp_q.size() == 0, "R7", "pending scoreboard items", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule